// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank

This block is a sixteen-pin general-purpose I/O bank with a byte-addressed register file of 16-bit words. Software picks a direction per pin, drives output levels, reads synchronised input levels and asks for an interrupt on a rising edge, a falling edge or either edge of any pin. Level sensing is not offered. The trigger choice for each pin is a 2-bit code. The codes are packed eight pins to a word across two trigger-configuration registers.

Detected edges latch into a pending-event register. Software clears that register by writing ones. A single interrupt line reports any pending event whose enable bit is set. A wake-up line reports any pending event whose wake-mask bit is set, but only while the wake gate in the system-configuration register is open. The enable mask, the wake mask and the output data each have a set alias and a clear alias. Either alias changes only the bits that are one in the written word, so software needs no read-modify-write.

The read port is combinational on the address. A write takes effect at the clock edge where `wrEn` is high.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the direction register (0x34) reads 0xFFFF. The output data (0x30), enable (0x1C), wake mask (0x28), pending (0x18), trigger (0x38, 0x3C) and system-configuration (0x10) registers read 0x0000. The revision register (0x00) reads the `REVISION` parameter. Bit 0 of the system-status register (0x14) reads 1 from the first clock after reset.
- R2: `dirIsIn` shows the direction register, where a 1 means the pin is an input. `padOut` shows the output data register.
- R3: A write to 0xF0 sets the output-data bits that are one in the written word. A write to 0xB0 clears them. Bits written as zero keep their value.
- R4: Writes to 0xDC and 0x9C set and clear enable bits. Writes to 0xE8 and 0xA8 set and clear wake-mask bits. In each case only the bits that are one in the written word change.
- R5: Pin p takes its trigger code from bits [2*(p mod 8)+1 : 2*(p mod 8)]. Pins 0 to 7 use register 0x38 and pins 8 to 15 use register 0x3C. The codes are 0 for none, 1 for falling, 2 for rising and 3 for both edges.
- R6: Each pad input passes through two flip-flops before it is used. The data-in register (0x2C) shows a pad change after the second clock edge following the change, and not after the first.
- R7: A write to the pending register (0x18) clears the bits that are one in the written word and leaves the others. Writing 0xFFFF clears every bit. No bit is cleared without such a write.
- R8: When an edge event and a clear write hit the same pending bit at the same clock edge, the bit stays set.
- R9: `irqOut` is high exactly when some pin has both its pending bit and its enable bit set.
- R10: `wakeOut` is high exactly when bit 2 of the system-configuration register is set and some pin has both its pending bit and its wake-mask bit set.
- R11: A pin whose trigger code is 0 never sets its pending bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| padIn | input | 16 | Asynchronous pad input levels |
| padOut | output | 16 | Output data levels |
| dirIsIn | output | 16 | Per-pin direction, 1 = input |
| irqOut | output | 1 | Interrupt request |
| wakeOut | output | 1 | Wake-up request |

## Verification
The checker watches four things on every cycle. A pending bit never falls unless a pending-register write preceded it. The interrupt line stays low while the enable mask is empty. The wake line stays low while the wake gate is closed. A clear alias leaves none of its written bits set, and a set alias leaves all of them set. Other behaviour can only be shown by the directed scenarios: the mapping from trigger code and field position to edge type, the exact two-stage input latency, and the winner when an edge and a clear land in the same cycle. Each of these depends on a particular sequence of pad and bus activity.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 8;
  localparam int FIELD_W   = 2;
  localparam int PINS_PER_CFG = DATA_W / FIELD_W;
  localparam int WAKE_GATE_BIT = 2;
  localparam int DONE_BIT  = 0;

  localparam logic [ADDR_W-1:0] OFS_REV     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SYSCFG  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SYSSTAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EN      = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WAKE    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_TRIGLO  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_TRIGHI  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_WK_CLR  = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_DO_CLR  = 8'hB0;
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 8'hDC;
  localparam logic [ADDR_W-1:0] OFS_WK_SET  = 8'hE8;
  localparam logic [ADDR_W-1:0] OFS_DO_SET  = 8'hF0;

  typedef struct packed {
    logic sysCfgWr;
    logic pendClr;
    logic enWr;
    logic enSet;
    logic enClr;
    logic wkWr;
    logic wkSet;
    logic wkClr;
    logic doWr;
    logic doSet;
    logic doClr;
    logic dirWr;
    logic trigLoWr;
    logic trigHiWr;
  } bankStrobes_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_REV, SEL_SYSCFG, SEL_SYSSTAT, SEL_PEND, SEL_EN,
    SEL_WAKE, SEL_DIN, SEL_DOUT, SEL_DIR, SEL_TRIGLO, SEL_TRIGHI
  } readSel_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobes_t      strb,
  output readSel_t          readSel
);
  always_comb begin
    strb    = '0;
    readSel = SEL_NONE;
    case (addr)
      OFS_REV:     readSel = SEL_REV;
      OFS_SYSCFG:  begin readSel = SEL_SYSCFG;  strb.sysCfgWr = wrEn; end
      OFS_SYSSTAT: readSel = SEL_SYSSTAT;
      OFS_PEND:    begin readSel = SEL_PEND;    strb.pendClr  = wrEn; end
      OFS_EN:      begin readSel = SEL_EN;      strb.enWr     = wrEn; end
      OFS_WAKE:    begin readSel = SEL_WAKE;    strb.wkWr     = wrEn; end
      OFS_DIN:     readSel = SEL_DIN;
      OFS_DOUT:    begin readSel = SEL_DOUT;    strb.doWr     = wrEn; end
      OFS_DIR:     begin readSel = SEL_DIR;     strb.dirWr    = wrEn; end
      OFS_TRIGLO:  begin readSel = SEL_TRIGLO;  strb.trigLoWr = wrEn; end
      OFS_TRIGHI:  begin readSel = SEL_TRIGHI;  strb.trigHiWr = wrEn; end
      OFS_EN_CLR:  strb.enClr = wrEn;
      OFS_EN_SET:  strb.enSet = wrEn;
      OFS_WK_CLR:  strb.wkClr = wrEn;
      OFS_WK_SET:  strb.wkSet = wrEn;
      OFS_DO_CLR:  strb.doClr = wrEn;
      OFS_DO_SET:  strb.doSet = wrEn;
      default:     readSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] REVISION = 16'h0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strb,
  input  readSel_t          readSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] doutQ,
  output logic [DATA_W-1:0] dirQ,
  output logic [DATA_W-1:0] pendQ,
  output logic [DATA_W-1:0] enQ,
  output logic [DATA_W-1:0] sysCfgQ,
  output logic              irqOut,
  output logic              wakeOut
);
  logic [DATA_W-1:0] wkQ, trigLoQ, trigHiQ;
  logic [DATA_W-1:0] syncA, syncB, prevB;
  logic [DATA_W-1:0] evtVec, clrMask;
  logic              doneQ;

  // Two-stage synchroniser plus one history stage for edge compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // Per-pin code unpacking and edge qualification
  for (genvar p = 0; p < DATA_W; p++) begin : g_pin
    logic [FIELD_W-1:0] code;
    logic rise, fall;
    if (p < PINS_PER_CFG) begin : g_lo
      assign code = trigLoQ[FIELD_W*p +: FIELD_W];
    end else begin : g_hi
      assign code = trigHiQ[FIELD_W*(p-PINS_PER_CFG) +: FIELD_W];
    end
    assign rise = syncB[p] & ~prevB[p];
    assign fall = ~syncB[p] & prevB[p];
    assign evtVec[p] = (code[1] & rise) | (code[0] & fall);
  end

  assign clrMask = strb.pendClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ   <= 1'b0;
      sysCfgQ <= '0;
      pendQ   <= '0;
      enQ     <= '0;
      wkQ     <= '0;
      doutQ   <= '0;
      dirQ    <= '1;
      trigLoQ <= '0;
      trigHiQ <= '0;
    end else begin
      doneQ <= 1'b1;
      // events win over a simultaneous clear of the same bit
      pendQ <= (pendQ & ~clrMask) | evtVec;
      if (strb.sysCfgWr) sysCfgQ <= wrData;
      if (strb.enWr)       enQ <= wrData;
      else if (strb.enSet) enQ <= enQ | wrData;
      else if (strb.enClr) enQ <= enQ & ~wrData;
      if (strb.wkWr)       wkQ <= wrData;
      else if (strb.wkSet) wkQ <= wkQ | wrData;
      else if (strb.wkClr) wkQ <= wkQ & ~wrData;
      if (strb.doWr)       doutQ <= wrData;
      else if (strb.doSet) doutQ <= doutQ | wrData;
      else if (strb.doClr) doutQ <= doutQ & ~wrData;
      if (strb.dirWr)    dirQ    <= wrData;
      if (strb.trigLoWr) trigLoQ <= wrData;
      if (strb.trigHiWr) trigHiQ <= wrData;
    end
  end

  assign irqOut  = |(pendQ & enQ);
  assign wakeOut = sysCfgQ[WAKE_GATE_BIT] & (|(pendQ & wkQ));

  always_comb begin
    rdData = '0;
    case (readSel)
      SEL_REV:     rdData = REVISION;
      SEL_SYSCFG:  rdData = sysCfgQ;
      SEL_SYSSTAT: rdData[DONE_BIT] = doneQ;
      SEL_PEND:    rdData = pendQ;
      SEL_EN:      rdData = enQ;
      SEL_WAKE:    rdData = wkQ;
      SEL_DIN:     rdData = syncB;
      SEL_DOUT:    rdData = doutQ;
      SEL_DIR:     rdData = dirQ;
      SEL_TRIGLO:  rdData = trigLoQ;
      SEL_TRIGHI:  rdData = trigHiQ;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] REVISION = 16'h0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] dirIsIn,
  output logic              irqOut,
  output logic              wakeOut
);
  bankStrobes_t      strb;
  readSel_t          readSel;
  logic [DATA_W-1:0] pendQ, enQ, sysCfgQ;

  gpio_bank_ctrl u_ctrl (
    .wrEn(wrEn), .addr(addr), .strb(strb), .readSel(readSel)
  );

  gpio_bank_dp #(.REVISION(REVISION)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .readSel(readSel),
    .wrData(wrData), .padIn(padIn), .rdData(rdData),
    .doutQ(padOut), .dirQ(dirIsIn), .pendQ(pendQ), .enQ(enQ),
    .sysCfgQ(sysCfgQ), .irqOut(irqOut), .wakeOut(wakeOut)
  );
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] padOut,
  input logic [DATA_W-1:0] pendQ,
  input logic [DATA_W-1:0] enQ,
  input logic [DATA_W-1:0] sysCfgQ,
  input logic              irqOut,
  input logic              wakeOut
);
  assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == OFS_PEND) |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irqOut);

  assert_wake_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !sysCfgQ[WAKE_GATE_BIT] |-> !wakeOut);

  assert_dout_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_DO_SET) |=> ((padOut & $past(wrData)) == $past(wrData)));

  assert_dout_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_DO_CLR) |=> ((padOut & $past(wrData)) == '0));

  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_EN_CLR) |=> ((enQ & $past(wrData)) == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .padOut(padOut), .pendQ(pendQ), .enQ(enQ), .sysCfgQ(sysCfgQ),
  .irqOut(irqOut), .wakeOut(wakeOut)
);

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;
  localparam logic [15:0] REV = 16'h0010;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wrData = 16'h0000;
  logic [15:0] rdData, padOut, dirIsIn;
  logic [15:0] padIn = 16'h0000;
  logic        irqOut, wakeOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_bank #(.REVISION(REV)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .dirIsIn(dirIsIn),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [15:0] v;
    rd(8'h34, v); chk("R1 dir", v, 16'hFFFF);
    rd(8'h30, v); chk("R1 dout", v, 16'h0000);
    rd(8'h1C, v); chk("R1 en", v, 16'h0000);
    rd(8'h18, v); chk("R1 pend", v, 16'h0000);
    rd(8'h14, v); chk("R1 sysstat", v, 16'h0001);
    rd(8'h00, v); chk("R1 rev", v, REV);
    chk("R1 irq", {15'd0, irqOut}, 16'h0000);
  endtask

  task automatic test_dir();
    wr(8'h34, 16'h00F0);
    wr(8'h30, 16'h1234);
    settle(1);
    chk("R2 dirIsIn", dirIsIn, 16'h00F0);
    chk("R2 padOut", padOut, 16'h1234);
  endtask

  task automatic test_alias();
    logic [15:0] v;
    wr(8'hF0, 16'h000F); settle(1); chk("R3 set", padOut, 16'h123F);
    wr(8'hB0, 16'h0230); settle(1); chk("R3 clr", padOut, 16'h100F);
    wr(8'hDC, 16'h0005); rd(8'h1C, v); chk("R4 en set", v, 16'h0005);
    wr(8'h9C, 16'h0004); rd(8'h1C, v); chk("R4 en clr", v, 16'h0001);
    wr(8'hE8, 16'h00F0); wr(8'hA8, 16'h0030);
    rd(8'h28, v); chk("R4 wake alias", v, 16'h00C0);
  endtask

  task automatic test_sync();
    logic [15:0] v;
    @(negedge clk); padIn = 16'hA5A5;
    rd(8'h2C, v); chk("R6 one stage", v, 16'h0000);
    rd(8'h2C, v); chk("R6 two stages", v, 16'hA5A5);
    @(negedge clk); padIn = 16'h0000;
    settle(4);
    rd(8'h18, v); chk("R11 code zero", v, 16'h0000);
  endtask

  task automatic test_codes();
    logic [15:0] v;
    wr(8'h38, 16'h0039);   // pin0 fall, pin1 rise, pin2 both, pin3 none
    wr(8'h3C, 16'h4002);   // pin8 rise, pin15 fall
    @(negedge clk); padIn = 16'h810F;
    settle(4);
    rd(8'h18, v); chk("R5 rising", v, 16'h0106);
    wr(8'h18, 16'hFFFF);
    rd(8'h18, v); chk("R7 clear all", v, 16'h0000);
    @(negedge clk); padIn = 16'h0000;
    settle(4);
    rd(8'h18, v); chk("R5 falling", v, 16'h8005);
    wr(8'h18, 16'h0001);
    rd(8'h18, v); chk("R7 partial", v, 16'h8004);
    wr(8'h18, 16'hFFFF);
  endtask

  task automatic test_irq();
    logic [15:0] v;
    @(negedge clk); padIn = 16'h0001;
    settle(4);
    chk("R9 no event", {15'd0, irqOut}, 16'h0000);
    @(negedge clk); padIn = 16'h0000;
    settle(4);
    chk("R9 raised", {15'd0, irqOut}, 16'h0001);
    wr(8'h9C, 16'h0001); settle(1);
    chk("R9 masked", {15'd0, irqOut}, 16'h0000);
    rd(8'h18, v); chk("R9 pend kept", v, 16'h0001);
    wr(8'h18, 16'hFFFF);
  endtask

  task automatic test_wake();
    wr(8'hE8, 16'h0004);
    @(negedge clk); padIn = 16'h0004;
    settle(4);
    chk("R10 gate closed", {15'd0, wakeOut}, 16'h0000);
    wr(8'h10, 16'h0004); settle(1);
    chk("R10 gate open", {15'd0, wakeOut}, 16'h0001);
    wr(8'h18, 16'hFFFF); settle(1);
    chk("R10 cleared", {15'd0, wakeOut}, 16'h0000);
  endtask

  task automatic test_priority();
    logic [15:0] v;
    @(negedge clk); padIn = 16'h0000;   // pin2 falls, code 3
    @(negedge clk);
    @(negedge clk);
    addr = 8'h18; wrData = 16'h0004; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    rd(8'h18, v); chk("R8 set wins", v, 16'h0004);
    wr(8'h18, 16'h0004);
    rd(8'h18, v); chk("R7 after race", v, 16'h0000);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(2);
    test_reset();
    test_dir();
    test_alias();
    test_sync();
    test_codes();
    test_irq();
    test_wake();
    test_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule